// File: doc/BRIEF.md
# Receive/Transmit FIFO Controller with Switchable Deep Mode

This block holds the byte queues of a 16550-style serial port and decodes the register that configures them. A receive queue is filled by the receive shifter and drained by the host. A transmit queue is filled by the host and drained by the transmit shifter. A single write to the FIFO control register does several things at once. It turns the queues on or off. It selects a standard depth of 16 entries or a deep depth of 64 entries. It clears either queue. It picks the receive threshold at which the data-available interrupt is raised.

When the queues are off, each direction behaves as a one-byte holding register. The block drives the three FIFO status bits of the interrupt identification register. Software reads these bits to learn whether the queues are active and whether the deep mode took effect. The block does not handle baud timing, shifting, line errors, character timeout or modem lines.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the queues are off, both counts are 0, the status bits read 3'b000, the interrupt is low, both overrun flags are 0 and both pop data outputs are 0.
- R2: A control write is taken only while `lcrDlab` is 0. A write presented while `lcrDlab` is 1 changes neither the mode nor the queue contents.
- R3: Control bit 0 turns the queues on. Bit 5 selects 64-entry mode only when it is written together with bit 0. Writing 0x00 turns the queues off and leaves the deep mode off. Capacity is 1 when the queues are off, 16 in standard mode and 64 in deep mode.
- R4: `iirFifoBits` reads 3'b000 when the queues are off, 3'b110 in standard mode and 3'b111 in deep mode.
- R5: In standard mode, the trigger field in control bits 7:6 selects a receive threshold. Encodings 00, 01, 10 and 11 select 1, 4, 8 and 14 bytes.
- R6: In deep mode the same encodings select thresholds of 1, 16, 32 and 56 bytes. With the queues off the threshold is 1.
- R7: `rxDataIrq` is high exactly while the receive count is at or above the selected threshold. It falls once pops bring the count below the threshold.
- R8: A taken write that changes the on/off state or the deep mode empties both queues and clears both overrun flags in the same edge.
- R9: A taken write with bit 1 set empties the receive queue. A taken write with bit 2 set empties the transmit queue. Neither bit touches the other queue.
- R10: Each queue returns bytes in the order they were pushed. A pop places the head byte on the pop data output after that clock edge.
- R11: A push to a full queue is discarded and sets that direction's sticky overrun flag. This holds even when a pop occurs in the same cycle. The flag stays set until that queue is emptied by a write.
- R12: A pop from an empty queue leaves the count at 0 and the pop data output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lcrDlab | input | 1 | Divisor-access bit of the line control register; blocks control writes when 1 |
| fcrWrEn | input | 1 | Control register write strobe |
| fcrWrData | input | 8 | Control register write value |
| rxPush | input | 1 | Receive shifter delivers a byte |
| rxPushData | input | 8 | Byte from the receive shifter |
| rxPop | input | 1 | Host reads a received byte |
| rxPopData | output | 8 | Most recently popped received byte |
| rxCount | output | 7 | Bytes in the receive queue |
| rxDataIrq | output | 1 | Receive data available at or above the threshold |
| rxOverrun | output | 1 | Sticky flag: a received byte was dropped |
| txPush | input | 1 | Host writes a byte to send |
| txPushData | input | 8 | Byte from the host |
| txPop | input | 1 | Transmit shifter takes a byte |
| txPopData | output | 8 | Most recently popped transmit byte |
| txCount | output | 7 | Bytes in the transmit queue |
| txOverrun | output | 1 | Sticky flag: a transmit byte was dropped |
| iirFifoBits | output | 3 | FIFO status bits 7:5 of the interrupt identification register |

## Verification
The queues are exercised under three configurations: off, standard and deep. In each one the bench fills a queue to one byte below each of the four trigger thresholds and then to the threshold itself. This separates the two threshold tables and shows that each encoding takes effect.

Further stimulus fills each queue past its capacity and pushes and pops together at the full level. The bench pops from an empty queue. It writes a mode bit while access is blocked, and it writes the deep bit without the enable bit. These cases separate a discard from a wrap, a real flush from a clear that only looks like one, and a taken write from one that was blocked.

A behavioural queue model is compared with every output on every cycle. As a result, the byte order and the interrupt edges are checked across all of this stimulus.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int DATA_W     = 8;
  localparam int STD_DEPTH  = 16;
  localparam int DEEP_DEPTH = 64;
  localparam int CNT_W      = $clog2(DEEP_DEPTH + 1);

  // strobes and limits handed from the control decode to the datapath
  typedef struct packed {
    logic             flushRx;
    logic             flushTx;
    logic [CNT_W-1:0] capacity;
    logic [CNT_W-1:0] rxThresh;
  } fifo_strobe_t;
endpackage

// File: rtl/uart_fifo_ring.sv
module uart_fifo_ring #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [CNT_W-1:0]  capacity,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] popData,
  output logic [CNT_W-1:0]  count,
  output logic              dropped
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic              pushOk;
  logic              popOk;

  // room is judged on the count before any pop of the same cycle
  assign pushOk = push && (count < capacity);
  assign popOk  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (pushOk && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      popData <= '0;
      dropped <= 1'b0;
    end else if (flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      dropped <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + 1'b1;
      if (popOk) begin
        rdPtr   <= rdPtr + 1'b1;
        popData <= mem[rdPtr];
      end
      count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
      if (push && !pushOk) dropped <= 1'b1;
    end
  end

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    count <= capacity);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0) && !dropped);

  p_empty_pop_r12: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && !flush && count == '0) |=> (count == '0) && $stable(popData));

  p_full_push_r11: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !flush && count == capacity) |=> $stable(count) && dropped);

  p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (dropped && !flush) |=> dropped);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         lcrDlab,
  input  logic         fcrWrEn,
  input  logic [7:0]   fcrWrData,
  output fifo_strobe_t strobe,
  output logic [2:0]   iirFifoBits
);
  localparam int BIT_ON   = 0;
  localparam int BIT_RXCL = 1;
  localparam int BIT_TXCL = 2;
  localparam int BIT_DEEP = 5;

  logic       fifoOn;
  logic       deepOn;
  logic [1:0] trigSel;
  logic       wrOk;
  logic       nextOn;
  logic       nextDeep;
  logic       modeChange;
  logic       unusedFcrBits;

  assign wrOk          = fcrWrEn && !lcrDlab;
  assign nextOn        = fcrWrData[BIT_ON];
  assign nextDeep      = fcrWrData[BIT_ON] & fcrWrData[BIT_DEEP];
  assign modeChange    = wrOk && ((nextOn != fifoOn) || (nextDeep != deepOn));
  assign unusedFcrBits = ^fcrWrData[4:3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoOn  <= 1'b0;
      deepOn  <= 1'b0;
      trigSel <= 2'b00;
    end else if (wrOk) begin
      fifoOn  <= nextOn;
      deepOn  <= nextDeep;
      trigSel <= fcrWrData[7:6];
    end
  end

  always_comb begin
    strobe.flushRx = modeChange || (wrOk && fcrWrData[BIT_RXCL]);
    strobe.flushTx = modeChange || (wrOk && fcrWrData[BIT_TXCL]);
    if (!fifoOn)     strobe.capacity = CNT_W'(1);
    else if (deepOn) strobe.capacity = CNT_W'(DEEP_DEPTH);
    else             strobe.capacity = CNT_W'(STD_DEPTH);
    if (!fifoOn) begin
      strobe.rxThresh = CNT_W'(1);
    end else if (deepOn) begin
      case (trigSel)
        2'b00:   strobe.rxThresh = CNT_W'(1);
        2'b01:   strobe.rxThresh = CNT_W'(16);
        2'b10:   strobe.rxThresh = CNT_W'(32);
        default: strobe.rxThresh = CNT_W'(56);
      endcase
    end else begin
      case (trigSel)
        2'b00:   strobe.rxThresh = CNT_W'(1);
        2'b01:   strobe.rxThresh = CNT_W'(4);
        2'b10:   strobe.rxThresh = CNT_W'(8);
        default: strobe.rxThresh = CNT_W'(14);
      endcase
    end
  end

  assign iirFifoBits = {fifoOn, fifoOn, deepOn};

  p_deep_needs_on_r3: assert property (@(posedge clk) disable iff (!rstN)
    deepOn |-> fifoOn);

  p_locked_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fcrWrEn && lcrDlab) |=> $stable(fifoOn) && $stable(deepOn) && $stable(trigSel));
endmodule

// File: rtl/uart_fifo_dp.sv
module uart_fifo_dp
  import uart_fifo_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int DEPTH = DEEP_DEPTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifo_strobe_t     strobe,
  input  logic             rxPush,
  input  logic [DW-1:0]    rxPushData,
  input  logic             rxPop,
  output logic [DW-1:0]    rxPopData,
  output logic [CNT_W-1:0] rxCount,
  output logic             rxDataIrq,
  output logic             rxOverrun,
  input  logic             txPush,
  input  logic [DW-1:0]    txPushData,
  input  logic             txPop,
  output logic [DW-1:0]    txPopData,
  output logic [CNT_W-1:0] txCount,
  output logic             txOverrun
);
  localparam int CH_RX = 0;
  localparam int CH_TX = 1;
  localparam int N_CH  = 2;

  logic [N_CH-1:0]  chPush;
  logic [N_CH-1:0]  chPop;
  logic [N_CH-1:0]  chFlush;
  logic [N_CH-1:0]  chDrop;
  logic [DW-1:0]    chIn  [N_CH];
  logic [DW-1:0]    chOut [N_CH];
  logic [CNT_W-1:0] chCnt [N_CH];

  assign chPush[CH_RX]  = rxPush;
  assign chPush[CH_TX]  = txPush;
  assign chPop[CH_RX]   = rxPop;
  assign chPop[CH_TX]   = txPop;
  assign chFlush[CH_RX] = strobe.flushRx;
  assign chFlush[CH_TX] = strobe.flushTx;
  assign chIn[CH_RX]    = rxPushData;
  assign chIn[CH_TX]    = txPushData;

  for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
    uart_fifo_ring #(
      .DATA_W (DW),
      .DEPTH  (DEPTH),
      .CNT_W  (CNT_W)
    ) u_ring (
      .clk      (clk),
      .rstN     (rstN),
      .flush    (chFlush[gi]),
      .capacity (strobe.capacity),
      .push     (chPush[gi]),
      .pushData (chIn[gi]),
      .pop      (chPop[gi]),
      .popData  (chOut[gi]),
      .count    (chCnt[gi]),
      .dropped  (chDrop[gi])
    );
  end

  assign rxPopData = chOut[CH_RX];
  assign txPopData = chOut[CH_TX];
  assign rxCount   = chCnt[CH_RX];
  assign txCount   = chCnt[CH_TX];
  assign rxOverrun = chDrop[CH_RX];
  assign txOverrun = chDrop[CH_TX];
  assign rxDataIrq = (chCnt[CH_RX] >= strobe.rxThresh);
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lcrDlab,
  input  logic             fcrWrEn,
  input  logic [7:0]       fcrWrData,
  input  logic             rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic             rxPop,
  output logic [DATA_W-1:0] rxPopData,
  output logic [CNT_W-1:0] rxCount,
  output logic             rxDataIrq,
  output logic             rxOverrun,
  input  logic             txPush,
  input  logic [DATA_W-1:0] txPushData,
  input  logic             txPop,
  output logic [DATA_W-1:0] txPopData,
  output logic [CNT_W-1:0] txCount,
  output logic             txOverrun,
  output logic [2:0]       iirFifoBits
);
  fifo_strobe_t strobe;

  uart_fifo_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lcrDlab     (lcrDlab),
    .fcrWrEn     (fcrWrEn),
    .fcrWrData   (fcrWrData),
    .strobe      (strobe),
    .iirFifoBits (iirFifoBits)
  );

  uart_fifo_dp #(
    .DW    (DATA_W),
    .DEPTH (DEEP_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rxPush     (rxPush),
    .rxPushData (rxPushData),
    .rxPop      (rxPop),
    .rxPopData  (rxPopData),
    .rxCount    (rxCount),
    .rxDataIrq  (rxDataIrq),
    .rxOverrun  (rxOverrun),
    .txPush     (txPush),
    .txPushData (txPushData),
    .txPop      (txPop),
    .txPopData  (txPopData),
    .txCount    (txCount),
    .txOverrun  (txOverrun)
  );
endmodule

// File: tb/uart_fifo_ctl_tb.sv
`timescale 1ns/100ps
module uart_fifo_ctl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lcrDlab = 1'b0;
  logic       fcrWrEn = 1'b0;
  logic [7:0] fcrWrData = 8'h00;
  logic       rxPush = 1'b0, rxPop = 1'b0, txPush = 1'b0, txPop = 1'b0;
  logic [7:0] rxPushData = 8'h00, txPushData = 8'h00;
  logic [7:0] rxPopData, txPopData;
  logic [6:0] rxCount, txCount;
  logic       rxDataIrq, rxOverrun, txOverrun;
  logic [2:0] iirFifoBits;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_fifo_ctl u_dut (
    .clk(clk), .rstN(rstN), .lcrDlab(lcrDlab), .fcrWrEn(fcrWrEn), .fcrWrData(fcrWrData),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop), .rxPopData(rxPopData),
    .rxCount(rxCount), .rxDataIrq(rxDataIrq), .rxOverrun(rxOverrun),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop), .txPopData(txPopData),
    .txCount(txCount), .txOverrun(txOverrun), .iirFifoBits(iirFifoBits)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] rxQ[$];
  logic [7:0] txQ[$];
  bit mOn, mDeep, mRxOv, mTxOv;
  logic [1:0] mTrig;
  logic [7:0] mRxOut, mTxOut;

  function automatic int thrOf(bit on, bit deep, logic [1:0] t);
    if (!on) return 1;
    if (deep) return (t == 0) ? 1 : (t == 1) ? 16 : (t == 2) ? 32 : 56;
    return (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOn = 0; mDeep = 0; mTrig = 0; mRxOv = 0; mTxOv = 0;
      mRxOut = 0; mTxOut = 0; rxQ.delete(); txQ.delete();
    end else begin
      int cap;
      bit fR, fT, nOn, nDeep, rxPopOk, rxPushOk, txPopOk, txPushOk;
      cap = !mOn ? 1 : (mDeep ? 64 : 16);
      fR = 0; fT = 0;
      if (fcrWrEn && !lcrDlab) begin
        nOn = fcrWrData[0];
        nDeep = fcrWrData[0] & fcrWrData[5];
        if (nOn != mOn || nDeep != mDeep) begin fR = 1; fT = 1; end
        if (fcrWrData[1]) fR = 1;
        if (fcrWrData[2]) fT = 1;
        mOn = nOn; mDeep = nDeep; mTrig = fcrWrData[7:6];
      end
      if (fR) begin rxQ.delete(); mRxOv = 0; end
      else begin
        rxPopOk = rxPop && rxQ.size() > 0;
        rxPushOk = rxPush && rxQ.size() < cap;
        if (rxPush && !rxPushOk) mRxOv = 1;
        if (rxPopOk) mRxOut = rxQ.pop_front();
        if (rxPushOk) rxQ.push_back(rxPushData);
      end
      if (fT) begin txQ.delete(); mTxOv = 0; end
      else begin
        txPopOk = txPop && txQ.size() > 0;
        txPushOk = txPush && txQ.size() < cap;
        if (txPush && !txPushOk) mTxOv = 1;
        if (txPopOk) mTxOut = txQ.pop_front();
        if (txPushOk) txQ.push_back(txPushData);
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      int expIir;
      expIir = mOn ? (mDeep ? 7 : 6) : 0;
      chk(rxCount == rxQ.size(), "R10 rxCount vs model", rxCount, rxQ.size());
      chk(txCount == txQ.size(), "R10 txCount vs model", txCount, txQ.size());
      chk(rxPopData == mRxOut, "R10 rxPopData order", rxPopData, mRxOut);
      chk(txPopData == mTxOut, "R10 txPopData order", txPopData, mTxOut);
      chk(rxDataIrq == (rxQ.size() >= thrOf(mOn, mDeep, mTrig)), "R7 rxDataIrq vs threshold",
          rxDataIrq, (rxQ.size() >= thrOf(mOn, mDeep, mTrig)));
      chk(iirFifoBits == expIir, "R4 iirFifoBits vs model", iirFifoBits, expIir);
      chk(rxOverrun == mRxOv, "R11 rxOverrun vs model", rxOverrun, mRxOv);
      chk(txOverrun == mTxOv, "R11 txOverrun vs model", txOverrun, mTxOv);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wrFcr(bit lock, logic [7:0] v);
    lcrDlab = lock; fcrWrEn = 1'b1; fcrWrData = v;
    @(negedge clk);
    fcrWrEn = 1'b0; lcrDlab = 1'b0;
  endtask

  task automatic pushRx(int n, int base);
    for (int i = 0; i < n; i++) begin
      rxPush = 1'b1; rxPushData = 8'(base + i);
      @(negedge clk);
    end
    rxPush = 1'b0;
  endtask

  task automatic popRx(int n);
    for (int i = 0; i < n; i++) begin rxPop = 1'b1; @(negedge clk); end
    rxPop = 1'b0;
  endtask

  task automatic pushTx(int n, int base);
    for (int i = 0; i < n; i++) begin
      txPush = 1'b1; txPushData = 8'(base + i);
      @(negedge clk);
    end
    txPush = 1'b0;
  endtask

  task automatic popTx(int n);
    for (int i = 0; i < n; i++) begin txPop = 1'b1; @(negedge clk); end
    txPop = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 1, 0);
      finishRun();
    end
  end

  int stdThr[4] = '{1, 4, 8, 14};
  int deepThr[4] = '{1, 16, 32, 56};
  logic [7:0] held;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(iirFifoBits == 0, "R1 status bits after reset", iirFifoBits, 0);
    chk(rxCount == 0 && txCount == 0, "R1 counts after reset", rxCount + txCount, 0);
    chk(rxDataIrq == 0, "R1 irq after reset", rxDataIrq, 0);
    chk(rxPopData == 0 && rxOverrun == 0, "R1 pop data and overrun after reset", rxPopData, 0);

    // queues off: one-byte holding register
    pushRx(2, 8'h10);
    chk(rxCount == 1, "R3 capacity 1 when off", rxCount, 1);
    chk(rxOverrun == 1, "R11 overrun when off", rxOverrun, 1);

    // blocked write
    wrFcr(1, 8'h01);
    chk(iirFifoBits == 0, "R2 blocked write keeps mode", iirFifoBits, 0);
    chk(rxCount == 1, "R2 blocked write keeps queue", rxCount, 1);

    // standard mode on
    wrFcr(0, 8'h01);
    chk(iirFifoBits == 3'b110, "R4 standard mode bits", iirFifoBits, 6);
    chk(rxCount == 0 && rxOverrun == 0, "R8 mode change flushes rx", rxCount, 0);

    for (int e = 0; e < 4; e++) begin
      wrFcr(0, {e[1:0], 6'b000011});
      chk(rxCount == 0, "R9 rx clear bit empties rx", rxCount, 0);
      pushRx(stdThr[e] - 1, 8'h20 + e * 16);
      chk(rxDataIrq == 0, "R5 below standard threshold", rxDataIrq, 0);
      pushRx(1, 8'h80);
      chk(rxDataIrq == 1, "R5 at standard threshold", rxDataIrq, 1);
    end
    pushRx(4, 8'h40);
    chk(rxCount == 16, "R11 standard queue saturates", rxCount, 16);
    chk(rxOverrun == 1, "R11 standard overrun set", rxOverrun, 1);
    popRx(16);
    chk(rxDataIrq == 0, "R7 irq falls after draining", rxDataIrq, 0);
    held = rxPopData;
    popRx(2);
    chk(rxCount == 0, "R12 empty pop keeps count", rxCount, 0);
    chk(rxPopData == held, "R12 empty pop keeps data", rxPopData, held);

    // transmit clear only
    pushRx(3, 8'h50);
    pushTx(5, 8'h60);
    popTx(2);
    wrFcr(0, 8'h05);
    chk(txCount == 0, "R9 tx clear bit empties tx", txCount, 0);
    chk(rxCount == 3, "R9 tx clear leaves rx", rxCount, 3);

    // deep mode
    wrFcr(0, 8'h21);
    chk(iirFifoBits == 3'b111, "R4 deep mode bits", iirFifoBits, 7);
    chk(rxCount == 0, "R8 deep switch flushes rx", rxCount, 0);
    for (int e = 0; e < 4; e++) begin
      wrFcr(0, {e[1:0], 6'b100011});
      pushRx(deepThr[e] - 1, 8'h00 + e);
      chk(rxDataIrq == 0, "R6 below deep threshold", rxDataIrq, 0);
      pushRx(1, 8'hA0);
      chk(rxDataIrq == 1, "R6 at deep threshold", rxDataIrq, 1);
    end
    pushRx(9, 8'hB0);
    chk(rxCount == 64, "R11 deep queue saturates", rxCount, 64);
    rxPush = 1'b1; rxPop = 1'b1; rxPushData = 8'hEE;
    @(negedge clk);
    rxPush = 1'b0; rxPop = 1'b0;
    chk(rxCount == 63, "R11 full push with pop discarded", rxCount, 63);
    popRx(8);
    chk(rxDataIrq == 0, "R7 irq falls below 56", rxDataIrq, 0);

    pushTx(66, 8'hC0);
    chk(txCount == 64 && txOverrun == 1, "R11 tx saturates with overrun", txCount, 64);
    popTx(3);

    // deep bit without enable
    wrFcr(0, 8'h20);
    chk(iirFifoBits == 0, "R3 deep bit alone ignored", iirFifoBits, 0);
    chk(txCount == 0 && txOverrun == 0, "R8 switching off flushes tx", txCount, 0);
    pushRx(2, 8'hD0);
    chk(rxCount == 1, "R3 capacity 1 after deep bit alone", rxCount, 1);

    wrFcr(0, 8'h21);
    wrFcr(0, 8'h00);
    chk(iirFifoBits == 0, "R3 zero write leaves deep mode", iirFifoBits, 0);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule